// File: doc/BRIEF.md
# Parallel Host Command Interface for a Dot-Matrix Display Controller

This block is the host side of a dot-matrix display controller. A host processor reaches it through an 8-bit parallel bus that runs in one of two cycle styles. In the first style one strobe is an active-high enable and the other is a read/not-write line. In the second style the two strobes are separate active-low read and write lines. A register-select line tells a display-data access apart from an instruction or status access. The level held on the host reset pin picks the bus style, and a falling edge on that pin starts a reset sequence.

Instruction writes are decoded into the configuration bits the display scanner uses: display on, column mirror, static drive, duty and start line. They also load the page and column pointers into display memory. Display-data writes and reads go out through a single-cycle memory port, and the column pointer advances after each access. A read-modify-write mode keeps the column fixed across reads so that a read followed by a write lands on the same byte. A status read returns busy, mirror, display-off and reset-in-progress flags at any time.

All pins are sampled through a synchronizer on the block clock. An access takes effect when its strobe completes.

Top module: `lcd_host_if`

## Requirements
- R1: When `hrst_pin` is high, `strb_a` is an active-high enable, `strb_b` high means read, and an access completes on the falling edge of `strb_a`. When `hrst_pin` is low, `strb_a` is an active-low read and `strb_b` is an active-low write, and an access completes when the asserted strobe returns high. `dout_oe` is high while a read strobe is active.
- R2: `rs` high selects a display-data access. `rs` low selects an instruction write or a status read.
- R3: Instruction codes set the configuration outputs. The code `1011_000v` sets `disp_on` to v, `1011_001v` sets `mirror`, `1011_010v` sets `static_drv` and `1011_011v` sets `duty32`. The code `100s_ssss` sets `start_line` to s when s is below LINES. Undefined codes have no effect.
- R4: The code `0ccc_cccc` sets the column to c, and is ignored when c is COLS or more. The code `1010_00pp` sets the page to p.
- R5: A data write stores the byte at (page, column) through a single `mem_we` pulse and then increments the column. The column saturates at COLS-1 and never moves to another page.
- R6: A data read returns the byte fetched by the previous data read (a one-access dummy latency). It then fetches the byte at the current address and increments the column.
- R7: Code `1100_0000` enters read-modify-write mode. In this mode reads leave the column unchanged and writes still increment it. Code `1100_0001` leaves the mode.
- R8: Code `1100_0010` clears the start line, page and column to 0 and leaves every other configuration bit unchanged.
- R9: A falling edge on `hrst_pin` returns all configuration and pointers to 0 and ends read-modify-write mode. For RST_CYC cycles afterwards the reset and busy flags are set, and instruction and data accesses are ignored.
- R10: The status byte is {busy, mirror, display off, reset in progress, 4'b0000}. Busy covers the reset period and any pending memory access.
- R11: `mem_we` and `mem_re` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low system reset |
| hrst_pin | input | 1 | Host reset pin: falling edge resets, level selects bus style |
| rs | input | 1 | Register select: 1 data, 0 instruction/status |
| strb_a | input | 1 | Enable (style high) or active-low read (style low) |
| strb_b | input | 1 | Read/not-write (style high) or active-low write (style low) |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data (status or read latch) |
| dout_oe | output | 1 | Read data drive enable |
| mem_we | output | 1 | Display memory write pulse |
| mem_re | output | 1 | Display memory read pulse |
| mem_page | output | PW | Memory page address |
| mem_col | output | CW | Memory column address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_re` |
| disp_on | output | 1 | Display enable |
| mirror | output | 1 | Column-to-segment order reversed |
| static_drv | output | 1 | Static all-on drive |
| duty32 | output | 1 | 1 selects the longer scan duty |
| start_line | output | LW | Memory line shown on the first common row |

## Verification
If the column pointer is wrong, the very next data write lands in the wrong memory cell, and a readback two accesses later returns the wrong byte. Sweeps near the column limit on every page show saturation errors within one access. Read-modify-write and dummy-read mistakes appear as an off-by-one byte on the second read after an address set. If the reset counter or the busy gating is wrong, a status read taken inside the reset window shows it at once, and so does an instruction issued during that window that wrongly changes `disp_on`.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;
   typedef enum logic [3:0] {
      OP_NONE, OP_COL, OP_LINE, OP_PAGE, OP_ON, OP_MIR,
      OP_STAT, OP_DUTY, OP_RMW_ON, OP_RMW_OFF, OP_CLR
   } host_op_e;
endpackage

// File: rtl/lcd_host_sync.sv
module lcd_host_sync #(
   parameter int SYNC = 2
) (
   input  logic       clk,
   input  logic       arst_n,
   input  logic       hrst_pin,
   input  logic       rs,
   input  logic       strb_a,
   input  logic       strb_b,
   input  logic [7:0] din,
   output logic       act,
   output logic       rd,
   output logic       cur_rs,
   output logic       ev,
   output logic       ev_rd,
   output logic       ev_rs,
   output logic [7:0] ev_din,
   output logic       hrst_fall
);
   localparam int BW = 12;
   localparam logic [BW-1:0] IDLE = 12'b0011_0000_0000;

   logic [BW-1:0] raw, s;
   assign raw = {hrst_pin, rs, strb_a, strb_b, din};

   if (SYNC == 0) begin : g_bypass
      assign s = raw;
   end else begin : g_chain
      logic [BW-1:0] stg [SYNC];
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) begin
            for (int i = 0; i < SYNC; i++) stg[i] <= IDLE;
         end else begin
            stg[0] <= raw;
            for (int i = 1; i < SYNC; i++) stg[i] <= stg[i-1];
         end
      end
      assign s = stg[SYNC-1];
   end

   logic style68, p_act, p_rd, p_rs, p_hrst;
   logic [7:0] p_din;

   assign style68 = s[11];
   assign cur_rs  = s[10];
   assign act     = style68 ? s[9] : (~s[9] | ~s[8]);
   assign rd      = style68 ? s[8] : ~s[9];

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         p_act <= 1'b0; p_rd <= 1'b0; p_rs <= 1'b0; p_hrst <= 1'b0; p_din <= '0;
      end else begin
         p_act <= act; p_rd <= rd; p_rs <= cur_rs; p_hrst <= s[11];
         if (act) p_din <= s[7:0];
      end
   end

   assign ev        = p_act & ~act;
   assign ev_rd     = p_rd;
   assign ev_rs     = p_rs;
   assign ev_din    = p_din;
   assign hrst_fall = p_hrst & ~s[11];
endmodule

// File: rtl/lcd_host_decode.sv
module lcd_host_decode
   import lcd_host_pkg::*;
(
   input  logic [7:0] code,
   output host_op_e   op
);
   always_comb begin
      op = OP_NONE;
      if (!code[7])                        op = OP_COL;
      else if (code[7:5] == 3'b100)        op = OP_LINE;
      else if (code[7:2] == 6'b1010_00)    op = OP_PAGE;
      else if (code[7:3] == 5'b1011_0) begin
         case (code[2:1])
            2'd0:    op = OP_ON;
            2'd1:    op = OP_MIR;
            2'd2:    op = OP_STAT;
            default: op = OP_DUTY;
         endcase
      end
      else if (code == 8'hC0)              op = OP_RMW_ON;
      else if (code == 8'hC1)              op = OP_RMW_OFF;
      else if (code == 8'hC2)              op = OP_CLR;
   end
endmodule

// File: rtl/lcd_host_ptr.sv
module lcd_host_ptr #(
   parameter int COLS  = 80,
   parameter int PAGES = 4,
   parameter int LINES = 32,
   localparam int CW = $clog2(COLS),
   localparam int PW = $clog2(PAGES),
   localparam int LW = $clog2(LINES)
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          clr,
   input  logic          set_col,
   input  logic [6:0]    col_arg,
   input  logic          set_page,
   input  logic [1:0]    page_arg,
   input  logic          set_line,
   input  logic [4:0]    line_arg,
   input  logic          inc,
   output logic [CW-1:0] col_q,
   output logic [PW-1:0] page_q,
   output logic [LW-1:0] line_q
);
   localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         col_q <= '0; page_q <= '0; line_q <= '0;
      end else if (clr) begin
         col_q <= '0; page_q <= '0; line_q <= '0;
      end else begin
         if (set_col && int'(col_arg) < COLS) col_q <= col_arg[CW-1:0];
         else if (inc && col_q != COL_LAST)   col_q <= col_q + 1'b1;
         if (set_page && int'(page_arg) < PAGES) page_q <= page_arg[PW-1:0];
         if (set_line && int'(line_arg) < LINES) line_q <= line_arg[LW-1:0];
      end
   end

   // R5
   col_range_chk: assert property (@(posedge clk) disable iff (!arst_n)
      int'(col_q) < COLS);
   // R4
   page_range_chk: assert property (@(posedge clk) disable iff (!arst_n)
      int'(page_q) < PAGES);
   // R5
   col_sat_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (col_q == COL_LAST && inc && !set_col && !clr) |=> col_q == COL_LAST);
endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
   import lcd_host_pkg::*;
#(
   parameter int COLS    = 80,
   parameter int PAGES   = 4,
   parameter int LINES   = 32,
   parameter int RST_CYC = 16,
   parameter int SYNC    = 2,
   localparam int CW = $clog2(COLS),
   localparam int PW = $clog2(PAGES),
   localparam int LW = $clog2(LINES),
   localparam int RW = $clog2(RST_CYC + 1)
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          hrst_pin,
   input  logic          rs,
   input  logic          strb_a,
   input  logic          strb_b,
   input  logic [7:0]    din,
   output logic [7:0]    dout,
   output logic          dout_oe,
   output logic          mem_we,
   output logic          mem_re,
   output logic [PW-1:0] mem_page,
   output logic [CW-1:0] mem_col,
   output logic [7:0]    mem_wdata,
   input  logic [7:0]    mem_rdata,
   output logic          disp_on,
   output logic          mirror,
   output logic          static_drv,
   output logic          duty32,
   output logic [LW-1:0] start_line
);
   if (COLS < 2 || COLS > 128) begin : g_bad_cols
      $error("COLS must lie in 2..128");
   end
   if (PAGES < 2 || PAGES > 4) begin : g_bad_pages
      $error("PAGES must lie in 2..4");
   end
   if (LINES < 2 || LINES > 32) begin : g_bad_lines
      $error("LINES must lie in 2..32");
   end
   if (RST_CYC < 1) begin : g_bad_rst
      $error("RST_CYC must be at least 1");
   end

   logic act, rd, cur_rs, ev, ev_rd, ev_rs, hrst_fall;
   logic [7:0] ev_din;

   lcd_host_sync #(.SYNC(SYNC)) u_sync (
      .clk(clk), .arst_n(arst_n), .hrst_pin(hrst_pin), .rs(rs),
      .strb_a(strb_a), .strb_b(strb_b), .din(din),
      .act(act), .rd(rd), .cur_rs(cur_rs), .ev(ev), .ev_rd(ev_rd),
      .ev_rs(ev_rs), .ev_din(ev_din), .hrst_fall(hrst_fall)
   );

   host_op_e op;
   lcd_host_decode u_dec (.code(ev_din), .op(op));

   logic [RW-1:0] rst_cnt;
   logic rst_busy, rd_wait, busy, accept, ins, dwr, drd, rmw;
   logic [7:0] rd_latch;

   assign rst_busy = (rst_cnt != '0);
   assign busy     = rst_busy | mem_we | mem_re | rd_wait;
   assign accept   = ev & ~busy & ~hrst_fall;
   assign ins      = accept & ~ev_rd & ~ev_rs;
   assign dwr      = accept & ~ev_rd &  ev_rs;
   assign drd      = accept &  ev_rd &  ev_rs;

   logic [CW-1:0] col_q;
   logic [PW-1:0] page_q;

   lcd_host_ptr #(.COLS(COLS), .PAGES(PAGES), .LINES(LINES)) u_ptr (
      .clk(clk), .arst_n(arst_n),
      .clr(hrst_fall | (ins && op == OP_CLR)),
      .set_col(ins && op == OP_COL),   .col_arg(ev_din[6:0]),
      .set_page(ins && op == OP_PAGE), .page_arg(ev_din[1:0]),
      .set_line(ins && op == OP_LINE), .line_arg(ev_din[4:0]),
      .inc(dwr | (drd & ~rmw)),
      .col_q(col_q), .page_q(page_q), .line_q(start_line)
   );

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         rst_cnt <= '0; rmw <= 1'b0;
         disp_on <= 1'b0; mirror <= 1'b0; static_drv <= 1'b0; duty32 <= 1'b0;
      end else if (hrst_fall) begin
         rst_cnt <= RW'(RST_CYC); rmw <= 1'b0;
         disp_on <= 1'b0; mirror <= 1'b0; static_drv <= 1'b0; duty32 <= 1'b0;
      end else begin
         if (rst_busy) rst_cnt <= rst_cnt - 1'b1;
         if (ins) begin
            case (op)
               OP_ON:      disp_on    <= ev_din[0];
               OP_MIR:     mirror     <= ev_din[0];
               OP_STAT:    static_drv <= ev_din[0];
               OP_DUTY:    duty32     <= ev_din[0];
               OP_RMW_ON:  rmw        <= 1'b1;
               OP_RMW_OFF: rmw        <= 1'b0;
               default:    ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         mem_we <= 1'b0; mem_re <= 1'b0; rd_wait <= 1'b0;
         mem_page <= '0; mem_col <= '0; mem_wdata <= '0; rd_latch <= '0;
      end else begin
         mem_we  <= dwr;
         mem_re  <= drd;
         rd_wait <= mem_re;
         if (dwr | drd) begin
            mem_page <= page_q;
            mem_col  <= col_q;
         end
         if (dwr) mem_wdata <= ev_din;
         if (rd_wait) rd_latch <= mem_rdata;
      end
   end

   assign dout_oe = act & rd;
   assign dout    = cur_rs ? rd_latch : {busy, mirror, ~disp_on, rst_busy, 4'b0000};

   // R11
   mem_excl_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !(mem_we && mem_re));
   // R11
   we_pulse_chk: assert property (@(posedge clk) disable iff (!arst_n)
      mem_we |=> !mem_we);
   // R9
   rst_start_chk: assert property (@(posedge clk) disable iff (!arst_n)
      hrst_fall |=> (rst_busy && !disp_on && col_q == '0));
   // R9
   rst_quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
      rst_busy |-> (!mem_we && !mem_re));
   // R7
   rmw_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (drd && rmw) |=> $stable(col_q));
endmodule

// File: tb/sim_lcd_host_if.sv
`timescale 1ns/1ps
module sim_lcd_host_if;
   localparam int NC = 80;

   logic clk = 1'b0, arst_n = 1'b0, hrst_pin = 1'b1, rs = 1'b0;
   logic strb_a = 1'b0, strb_b = 1'b1;
   logic [7:0] din = '0, dout, mem_wdata, mem_rdata;
   logic dout_oe, mem_we, mem_re, disp_on, mirror, static_drv, duty32;
   logic [1:0] mem_page;
   logic [6:0] mem_col;
   logic [4:0] start_line;
   logic m68 = 1'b1;
   int checks = 0, errors = 0;
   logic [7:0] ram [0:4*NC-1];
   logic [7:0] q;

   always #5 clk = ~clk;

   lcd_host_if #(.RST_CYC(60)) u0 (
      .clk(clk), .arst_n(arst_n), .hrst_pin(hrst_pin), .rs(rs),
      .strb_a(strb_a), .strb_b(strb_b), .din(din), .dout(dout),
      .dout_oe(dout_oe), .mem_we(mem_we), .mem_re(mem_re),
      .mem_page(mem_page), .mem_col(mem_col), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .disp_on(disp_on), .mirror(mirror),
      .static_drv(static_drv), .duty32(duty32), .start_line(start_line)
   );

   always @(posedge clk) begin
      if (mem_we) ram[int'(mem_page)*NC + int'(mem_col)] <= mem_wdata;
      mem_rdata <= ram[int'(mem_page)*NC + int'(mem_col)];
   end

   task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
      checks++;
      if (act_v !== exp_v) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
      end
   endtask

   task automatic acc(input logic rsv, input logic rdv, input logic [7:0] d, output logic [7:0] rq);
      rs = rsv; din = d;
      if (m68) strb_b = rdv;
      @(negedge clk);
      if (m68) strb_a = 1'b1;
      else if (rdv) strb_a = 1'b0;
      else strb_b = 1'b0;
      repeat (5) @(negedge clk);
      rq = dout;
      if (rdv) chk("R1 oe", dout_oe, 1'b1);
      if (m68) strb_a = 1'b0;
      else begin strb_a = 1'b1; strb_b = 1'b1; end
      repeat (8) @(negedge clk);
      if (m68) strb_b = 1'b1;
   endtask

   task automatic cmd(input logic [7:0] d);
      logic [7:0] t;
      acc(1'b0, 1'b0, d, t);
   endtask
   task automatic wr(input logic [7:0] d);
      logic [7:0] t;
      acc(1'b1, 1'b0, d, t);
   endtask
   task automatic rdd(output logic [7:0] r);
      acc(1'b1, 1'b1, 8'h00, r);
   endtask
   task automatic st(output logic [7:0] r);
      acc(1'b0, 1'b1, 8'h00, r);
   endtask

   function automatic logic [7:0] pat(input int p, input int i);
      return 8'((p * 37 + i * 5 + 3) & 255);
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      arst_n = 1'b1;
      repeat (4) @(negedge clk);
      // reset state, R10
      chk("R10 reset cfg", {disp_on, mirror, static_drv, duty32, start_line}, 9'h0);
      st(q); chk("R10 reset status", q, 8'h20);

      // R3 configuration codes
      cmd(8'hB1); chk("R3 disp_on", disp_on, 1'b1);
      cmd(8'hB3); chk("R3 mirror", mirror, 1'b1);
      cmd(8'hB5); chk("R3 static", static_drv, 1'b1);
      cmd(8'hB7); chk("R3 duty", duty32, 1'b1);
      cmd(8'hB4); chk("R3 static off", static_drv, 1'b0);
      cmd(8'h95); chk("R3 line", start_line, 5'd21);
      cmd(8'hE7); chk("R3 undefined", {disp_on, mirror, duty32, start_line}, {3'b111, 5'd21});
      st(q); chk("R10 status", q, 8'h40);

      // R5 sweep: every page, writes run into the column limit
      for (int p = 0; p < 4; p++) begin
         cmd(8'hA0 | 8'(p));
         cmd(8'd76);
         for (int i = 0; i < 5; i++) wr(pat(p, i));
      end
      for (int p = 0; p < 4; p++) begin
         for (int i = 0; i < 3; i++)
            chk("R5 write", ram[p*NC + 76 + i], pat(p, i));
         chk("R5 saturate", ram[p*NC + 79], pat(p, 4));
      end
      // R2 rs high is data: readback with dummy latency, R6
      for (int p = 0; p < 4; p++) begin
         cmd(8'hA0 | 8'(p));
         cmd(8'd76);
         rdd(q);
         for (int i = 0; i < 3; i++) begin
            rdd(q); chk("R6 R2 read", q, pat(p, i));
         end
      end

      // R4 out-of-range column is ignored
      cmd(8'hA1); cmd(8'd5); cmd(8'd80); wr(8'hE1);
      chk("R4 col ignore", ram[NC + 5], 8'hE1);
      chk("R4 no wrap", ram[NC + 80 - 75], 8'hE1);

      // R7 read-modify-write
      cmd(8'hC0); cmd(8'hA2); cmd(8'd20);
      wr(8'h11); cmd(8'd20);
      rdd(q); rdd(q); chk("R7 rmw read", q, 8'h11);
      rdd(q); chk("R7 rmw hold", q, 8'h11);
      wr(8'h22);
      chk("R7 rmw write", ram[2*NC + 20], 8'h22);
      wr(8'h33);
      chk("R7 rmw inc", ram[2*NC + 21], 8'h33);
      cmd(8'hC1); cmd(8'd30); wr(8'h44); wr(8'h55);
      cmd(8'd30); rdd(q); rdd(q); chk("R7 end read", q, 8'h44);
      rdd(q); chk("R7 end inc", q, 8'h55);

      // R8 clear command
      cmd(8'hC2); wr(8'h3C);
      chk("R8 origin", ram[0], 8'h3C);
      chk("R8 line", start_line, 5'd0);
      chk("R8 keep", {disp_on, mirror}, 2'b11);

      // R9 host reset pulse, accesses during busy ignored
      @(negedge clk); hrst_pin = 1'b0;
      repeat (3) @(negedge clk); hrst_pin = 1'b1;
      repeat (2) @(negedge clk);
      st(q); chk("R9 R10 busy status", q, 8'hB0);
      cmd(8'hB1); wr(8'h99);
      repeat (80) @(negedge clk);
      chk("R9 ins ignored", disp_on, 1'b0);
      chk("R9 write ignored", ram[0], 8'h3C);
      chk("R9 defaults", {mirror, duty32}, 2'b00);
      st(q); chk("R9 idle status", q, 8'h20);

      // R1 switch to the separate-strobe style
      @(negedge clk); hrst_pin = 1'b0; strb_a = 1'b1; strb_b = 1'b1; m68 = 1'b0;
      repeat (80) @(negedge clk);
      cmd(8'hB3); chk("R1 style2 cmd", mirror, 1'b1);
      st(q); chk("R1 style2 status", q, 8'h60);
      cmd(8'hA3); cmd(8'd79); wr(8'h5A); wr(8'hA5);
      chk("R1 R5 style2 write", ram[3*NC + 79], 8'hA5);
      cmd(8'd78); wr(8'h77);
      cmd(8'd78); rdd(q); rdd(q); chk("R1 style2 read", q, 8'h77);
      rdd(q); chk("R6 sat read", q, 8'hA5);
      rdd(q); chk("R6 sat read2", q, 8'hA5);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule